// File: doc/BRIEF.md
# Reset Cause Register

This block keeps a small set of sticky flags that tell software which event caused the last chip reset. Four sources are tracked: power-on reset, the external reset pin, a watchdog timeout with its reset action enabled, and a supply brown-out. Each flag has its own rules for when it is set and which other sources clear it. Because of these rules, software can still tell the causes apart when resets overlap or follow one another, for example a pin held through power-up, or a brown-out that either recovers or decays into a full power cycle.

All inputs arrive as digital, already synchronized levels. The analog level detectors sit outside the block. The register lives in a domain that none of the recorded resets clear. It has its own domain reset, which only initializes it. Each flag updates on the first clock edge after its input condition changes. Software reads the register at any time. It clears a flag by writing a one to that bit position.

The read value is 8 bits wide. The bit positions are: bit 0 power-on, bit 1 external pin, bit 2 watchdog, bit 3 brown-out, and bits 7:4 always 0.

Top module: `reset_cause_reg`

## Requirements
- R1: While `porIn` is high, the next edge sets bit 0 and clears bits 1, 2 and 3, so `rdData` reads 8'h01.
- R2: If the external pin (or another source) is still active once `porIn` falls, its bit is set on the next edge, even though power-on had just cleared it.
- R3: Bit 1 is set on each edge where `extIn` is high and `porIn` is low. Only power-on and a software write clear it; watchdog and brown-out activity leave it unchanged.
- R4: Bit 2 is set only when `wdtTimeout` and `wdtEnable` are both high and no other source is active. A timeout with `wdtEnable` low does not set it. `porIn`, `extIn` or `bodIn` high clears it.
- R5: Bit 3 is set while `bodIn` is high and the supply has not collapsed since the last recovery. The bit stays set after `bodIn` falls again (a dip with recovery).
- R6: `collapseIn` high clears bit 3. After a collapse, bit 3 stays clear until `bodIn` falls (the supply climbs back above the brown-out threshold), and it is set on that edge.
- R7: External-pin and watchdog activity never change bit 3.
- R8: Bits 7:4 of `rdData` always read 0.
- R9: With `wrEn` high, each `wrData` bit at 1 clears the matching flag on the next edge. A 0 bit leaves that flag unchanged.
- R10: When a software clear and a hardware set hit the same flag on the same edge, the set wins.
- R11: After the domain reset `rstN`, all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-domain clock |
| rstN | input | 1 | Active-low reset of the register domain only |
| porIn | input | 1 | Power-on reset active |
| extIn | input | 1 | External reset pin active |
| wdtTimeout | input | 1 | Watchdog has timed out |
| wdtEnable | input | 1 | Watchdog reset action enabled |
| bodIn | input | 1 | Supply below the brown-out threshold |
| collapseIn | input | 1 | Supply fell to the power-on level |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 4 | Write-one-to-clear mask for flags 3:0 |
| rdData | output | 8 | Register read value |

## Verification
The assertions assume that the inputs are synchronous to `clk` and change only between edges. They also assume that `collapseIn` only goes high while `bodIn` is high, since a supply that reaches the power-on level has already passed the brown-out threshold. The bench meets both assumptions: it drives every input on the falling clock edge, and in its decay scenario it raises `bodIn` before `collapseIn` and keeps it high until the collapse and the power-on pulse are over. Within these limits the scenarios overlap sources on purpose: the pin held through power-on, a watchdog timeout during a pin reset, and software clears that coincide with active sources.

// File: rtl/reset_cause_pkg.sv
package reset_cause_pkg;
  localparam int SRC_N = 4;
  localparam int REG_W = 8;
  localparam int POR_BIT = 0;
  localparam int EXT_BIT = 1;
  localparam int WDT_BIT = 2;
  localparam int BOD_BIT = 3;

  typedef struct packed {
    logic [SRC_N-1:0] setV;
    logic [SRC_N-1:0] clrV;
  } strobe_t;
endpackage

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import reset_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             porIn,
  input  logic             extIn,
  input  logic             wdtTimeout,
  input  logic             wdtEnable,
  input  logic             bodIn,
  input  logic             collapseIn,
  input  logic             wrEn,
  input  logic [SRC_N-1:0] wrData,
  output strobe_t          strb
);
  logic bodPrev;
  logic decayed;
  logic bodFall;
  logic wdtHit;
  logic [SRC_N-1:0] swClr;

  assign bodFall = bodPrev && !bodIn;
  assign wdtHit  = wdtTimeout && wdtEnable;
  assign swClr   = wrEn ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bodPrev <= 1'b0;
      decayed <= 1'b0;
    end else begin
      bodPrev <= bodIn;
      if (collapseIn) decayed <= 1'b1;
      else if (bodFall) decayed <= 1'b0;
    end
  end

  always_comb begin
    strb = '0;
    strb.setV[POR_BIT] = porIn;
    strb.clrV[POR_BIT] = swClr[POR_BIT];

    strb.setV[EXT_BIT] = extIn && !porIn;
    strb.clrV[EXT_BIT] = porIn || swClr[EXT_BIT];

    strb.setV[WDT_BIT] = wdtHit && !porIn && !extIn && !bodIn;
    strb.clrV[WDT_BIT] = porIn || extIn || bodIn || swClr[WDT_BIT];

    strb.setV[BOD_BIT] = !porIn && !collapseIn &&
                         ((bodIn && !decayed) || (bodFall && decayed));
    strb.clrV[BOD_BIT] = porIn || collapseIn || swClr[BOD_BIT];
  end
endmodule

// File: rtl/reset_cause_flags.sv
module reset_cause_flags
  import reset_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [SRC_N-1:0] flags
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else if (strb.setV[i]) flags[i] <= 1'b1;
      else if (strb.clrV[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import reset_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             porIn,
  input  logic             extIn,
  input  logic             wdtTimeout,
  input  logic             wdtEnable,
  input  logic             bodIn,
  input  logic             collapseIn,
  input  logic             wrEn,
  input  logic [SRC_N-1:0] wrData,
  output logic [REG_W-1:0] rdData
);
  strobe_t strb;
  logic [SRC_N-1:0] flags;

  reset_cause_ctrl ctrl (
    .clk(clk), .rstN(rstN), .porIn(porIn), .extIn(extIn),
    .wdtTimeout(wdtTimeout), .wdtEnable(wdtEnable), .bodIn(bodIn),
    .collapseIn(collapseIn), .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  reset_cause_flags dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flags(flags)
  );

  assign rdData = {{(REG_W-SRC_N){1'b0}}, flags};
endmodule

// File: rtl/reset_cause_reg_chk.sv
module reset_cause_reg_chk
  import reset_cause_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             porIn,
  input logic             extIn,
  input logic             wdtTimeout,
  input logic             wdtEnable,
  input logic             bodIn,
  input logic             collapseIn,
  input logic             wrEn,
  input logic [SRC_N-1:0] wrData,
  input logic [REG_W-1:0] rdData
);
  // R1
  por_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    porIn |=> rdData[SRC_N-1:0] == 4'b0001);

  // R3
  ext_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extIn && !porIn) |=> rdData[EXT_BIT]);

  // R3
  ext_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[EXT_BIT] && !porIn && !wrEn) |=> rdData[EXT_BIT]);

  // R4
  wdt_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[WDT_BIT]) |-> $past(wdtTimeout && wdtEnable));

  // R4
  wdt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (porIn || extIn || bodIn) |=> !rdData[WDT_BIT]);

  // R6
  bod_collapse_chk: assert property (@(posedge clk) disable iff (!rstN)
    collapseIn |=> !rdData[BOD_BIT]);

  // R7
  bod_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!porIn && !collapseIn && !wrEn && $stable(bodIn)) |=>
      ($past(rdData[BOD_BIT]) ? rdData[BOD_BIT] : 1'b1));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:SRC_N] == '0);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (extIn && !porIn && wrEn && wrData[EXT_BIT]) |=> rdData[EXT_BIT]);
endmodule

bind reset_cause_reg reset_cause_reg_chk chk (.*);

// File: tb/reset_cause_reg_test.sv
`timescale 1ns/1ps
module reset_cause_reg_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porIn = 0, extIn = 0, wdtTimeout = 0, wdtEnable = 0;
  logic bodIn = 0, collapseIn = 0, wrEn = 0;
  logic [3:0] wrData = 4'h0;
  logic [7:0] rdData;

  int nCmp = 0;
  int nBad = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  bit mPor, mExt, mWdt, mBod, mDecay, mPrevBod;

  always #5 clk = ~clk;

  reset_cause_reg uut (
    .clk(clk), .rstN(rstN), .porIn(porIn), .extIn(extIn),
    .wdtTimeout(wdtTimeout), .wdtEnable(wdtEnable), .bodIn(bodIn),
    .collapseIn(collapseIn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] modelVal();
    return {4'h0, mBod, mWdt, mExt, mPor};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPor = 0; mExt = 0; mWdt = 0; mBod = 0; mDecay = 0; mPrevBod = 0;
    end else begin
      bit fell;
      fell = mPrevBod && !bodIn;
      if (wrEn) begin
        if (wrData[0]) mPor = 0;
        if (wrData[1]) mExt = 0;
        if (wrData[2]) mWdt = 0;
        if (wrData[3]) mBod = 0;
      end
      if (porIn) begin
        mPor = 1; mExt = 0; mWdt = 0; mBod = 0;
      end else begin
        if (extIn) begin mExt = 1; mWdt = 0; end
        if (bodIn) mWdt = 0;
        if (wdtTimeout && wdtEnable && !extIn && !bodIn) mWdt = 1;
        if (collapseIn) mBod = 0;
        else if (bodIn && !mDecay) mBod = 1;
        else if (fell && mDecay) mBod = 1;
      end
      if (collapseIn) mDecay = 1;
      else if (fell) mDecay = 0;
      mPrevBod = bodIn;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: rdData=%02h expected %02h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, one line per field
  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      logic [7:0] e;
      e = modelVal();
      check("R1 por bit",  {7'h0, rdData[0]}, {7'h0, e[0]});
      check("R3 ext bit",  {7'h0, rdData[1]}, {7'h0, e[1]});
      check("R4 wdt bit",  {7'h0, rdData[2]}, {7'h0, e[2]});
      check("R5 bod bit",  {7'h0, rdData[3]}, {7'h0, e[3]});
      check("R8 upper",    {4'h0, rdData[7:4]}, 8'h00);
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000 && !done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: run hung, rdData=%02h expected completion", rdData);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic swClear(logic [3:0] m);
    wrEn = 1; wrData = m; tick(1); wrEn = 0; wrData = 4'h0;
  endtask

  initial begin
    tick(3);
    check("R11 reset value", rdData, 8'h00);
    rstN = 1;
    tick(2);
    check("R11 idle after reset", rdData, 8'h00);

    // power-on with the pin held through it
    porIn = 1; extIn = 1; tick(3);
    check("R1 por with pin held", rdData, 8'h01);
    porIn = 0; tick(1);
    check("R2 pin still held after por", rdData, 8'h03);
    extIn = 0; tick(2);

    // software clear
    swClear(4'h0); tick(1);
    check("R9 write zero keeps flags", rdData, 8'h03);
    swClear(4'h2); tick(1);
    check("R9 write one clears ext", rdData, 8'h01);

    // watchdog, then external reset
    wdtTimeout = 1; wdtEnable = 0; tick(2);
    check("R4 timeout without enable", rdData, 8'h01);
    wdtEnable = 1; tick(1);
    check("R4 timeout with enable", rdData, 8'h05);
    wdtTimeout = 0; tick(1);
    check("R3 wdt keeps ext clear", rdData, 8'h05);
    extIn = 1; tick(1);
    check("R4 ext clears wdt", rdData, 8'h03);
    extIn = 0; wdtEnable = 0; tick(2);

    // brown-out dip and recovery
    bodIn = 1; tick(1);
    check("R5 dip sets bod", rdData, 8'h0B);
    bodIn = 0; tick(2);
    check("R5 bod stays after recovery", rdData, 8'h0B);
    extIn = 1; wdtTimeout = 1; wdtEnable = 1; tick(2);
    extIn = 0; tick(1);
    check("R7 ext and wdt leave bod", rdData, 8'h0F);
    wdtTimeout = 0; wdtEnable = 0;
    bodIn = 1; tick(1);
    check("R3 bod leaves ext", rdData, 8'h0B);
    bodIn = 0; tick(1);
    swClear(4'hF); tick(1);
    check("R9 clear all", rdData, 8'h00);

    // brown-out decaying to power-on
    bodIn = 1; tick(1);
    check("R5 second dip", rdData, 8'h08);
    collapseIn = 1; tick(1);
    check("R6 collapse clears bod", rdData, 8'h00);
    porIn = 1; tick(2);
    check("R6 por during collapse", rdData, 8'h01);
    collapseIn = 0; porIn = 0; tick(3);
    check("R6 bod held low while rising", rdData, 8'h01);
    bodIn = 0; tick(1);
    check("R6 rise above threshold sets bod", rdData, 8'h09);

    // clear colliding with an active source
    extIn = 1; tick(1);
    swClear(4'h2); tick(1);
    check("R10 set wins over clear", rdData, 8'h0B);
    extIn = 0; tick(1);
    swClear(4'h2); tick(1);
    check("R9 clear after release", rdData, 8'h09);

    // software cannot reach upper bits; value stays zero there
    swClear(4'h0); tick(1);
    check("R8 upper bits zero", {rdData[7:4], 4'h0}, 8'h00);

    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule